// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block sits inside a flash command controller, between the command decoder and the erase engine. When the decoder accepts a sector-erase command it gives this block a pulse and a sector index. The block collects the selected sectors into a bitmap and opens an acceptance window. Every further sector-erase command that arrives while the window is open adds its sector to the bitmap and starts the full time-out again.

When the time-out runs out, the block raises the erase-begun status bit (read by software as status bit 3). At the same moment it emits a one-cycle start pulse, and the complete bitmap goes to the erase engine. From then on the controller is locked. Every command other than erase suspend is flagged as rejected, and a suspend is passed through on its own pin. A chip-erase request skips the window and locks at once with every sector selected. An erase-done input from the engine clears the block back to idle.

The time-out is a cycle count derived from the clock frequency and a 50 µs window. Commands arrive as single-cycle strobes with no back-pressure. The erase engine must take the start pulse in the cycle it is presented, because the block offers no ready handshake and never stalls.

Top module: `sect_erase_window`

## Requirements
- R1: After reset, erase_begun, window_open, sector_map, erase_start, erase_chip, cmd_reject and suspend_out are all 0.
- R2: In idle, a command with cmd_op=1 (sector erase) opens the window in the next cycle. window_open goes to 1, erase_begun stays 0, and bit cmd_sector of sector_map is set.
- R3: erase_begun rises exactly TIMEOUT_CYC clock edges after the edge that accepted the last sector-erase command. It stays 0 while the window is open.
- R4: While the window is open, each sector-erase command ORs its sector into sector_map and restarts the full TIMEOUT_CYC count.
- R5: erase_start is a one-cycle pulse, high in the first cycle of erase_begun=1, and sector_map then holds every selected sector.
- R6: In idle, a command with cmd_op=2 (chip erase) bypasses the window. In the next cycle erase_begun=1, erase_start=1, erase_chip=1 and sector_map is all ones.
- R7: While erase_begun=1, any command with cmd_op other than 3 gives a one-cycle cmd_reject in the next cycle and leaves sector_map unchanged.
- R8: While erase_begun=1, a command with cmd_op=3 (erase suspend) gives a one-cycle suspend_out in the next cycle and no cmd_reject. In idle, a suspend has no effect.
- R9: erase_done while erase_begun=1 returns the block to idle in the next cycle, with erase_begun, erase_chip and sector_map cleared. erase_done in any other state is ignored.
- R10: While the window is open, a command with cmd_op other than 1 gives cmd_reject in the next cycle. It does not restart the count and does not change sector_map.
- R11: In idle, a command with cmd_op=0 has no effect: no reject, no window, and the bitmap stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for an accepted command |
| cmd_op | input | 2 | Command kind: 0 other, 1 sector erase, 2 chip erase, 3 erase suspend |
| cmd_sector | input | SECT_W | Sector index of a sector-erase command |
| erase_done | input | 1 | Erase engine has finished |
| erase_begun | output | 1 | Status bit 3: internal erase has begun |
| window_open | output | 1 | Acceptance window for extra sectors is open |
| sector_map | output | NUM_SECT | Bitmap of selected sectors |
| erase_start | output | 1 | One-cycle pulse that starts the erase engine |
| erase_chip | output | 1 | The current erase is a chip erase |
| cmd_reject | output | 1 | One-cycle flag: previous command was ignored |
| suspend_out | output | 1 | One-cycle pass-through of erase suspend |

## Verification
The bench builds the block with NUM_SECT=8 and TIMEOUT_CYC=20 rather than the default 5000-cycle window. This makes it affordable to walk through many complete windows: expiry, restarts late in the window, and rejected commands landing on the expiry cycle. The eight-sector map with a 3-bit index keeps every bit reachable under random indices. The short count still exercises the full reload-then-decrement path that sets the R3 timing.

// File: rtl/sew_pkg.sv
package sew_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_SECT  = 2'd1,
    OP_CHIP  = 2'd2,
    OP_SUSP  = 2'd3
  } sew_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_LOCKED = 2'd2
  } sew_state_e;
endpackage

// File: rtl/sew_timer.sv
module sew_timer #(
  parameter int TIMEOUT_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= LOAD_VAL;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sew_map.sv
module sew_map #(
  parameter int NUM_SECT = 16,
  parameter int SECT_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                fill,
  input  logic                set_en,
  input  logic [SECT_W-1:0]   set_idx,
  output logic [NUM_SECT-1:0] map
);
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                  map[i] <= 1'b0;
      else if (clr)                                map[i] <= 1'b0;
      else if (fill)                               map[i] <= 1'b1;
      else if (set_en && set_idx == SECT_W'(i))    map[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl
  import sew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       erase_done,
  input  logic       expired,
  output logic       t_load,
  output logic       t_run,
  output logic       m_clr,
  output logic       m_fill,
  output logic       m_set,
  output sew_state_e state,
  output logic       start_q,
  output logic       chip_q,
  output logic       rej_q,
  output logic       susp_q
);
  sew_op_e    op;
  sew_state_e nxt;
  logic       start_d, chip_d, rej_d, susp_d;

  assign op = sew_op_e'(cmd_op);

  always_comb begin
    nxt     = state;
    t_load  = 1'b0;
    t_run   = 1'b0;
    m_clr   = 1'b0;
    m_fill  = 1'b0;
    m_set   = 1'b0;
    start_d = 1'b0;
    rej_d   = 1'b0;
    susp_d  = 1'b0;
    chip_d  = chip_q;
    case (state)
      ST_IDLE: begin
        if (cmd_valid && op == OP_SECT) begin
          m_set  = 1'b1;
          t_load = 1'b1;
          nxt    = ST_WINDOW;
        end else if (cmd_valid && op == OP_CHIP) begin
          m_fill  = 1'b1;
          chip_d  = 1'b1;
          start_d = 1'b1;
          nxt     = ST_LOCKED;
        end
      end
      ST_WINDOW: begin
        if (cmd_valid && op == OP_SECT) begin
          m_set  = 1'b1;
          t_load = 1'b1;
        end else begin
          rej_d = cmd_valid;
          if (expired) begin
            start_d = 1'b1;
            nxt     = ST_LOCKED;
          end else begin
            t_run = 1'b1;
          end
        end
      end
      ST_LOCKED: begin
        if (cmd_valid) begin
          susp_d = (op == OP_SUSP);
          rej_d  = (op != OP_SUSP);
        end
        if (erase_done) begin
          m_clr  = 1'b1;
          chip_d = 1'b0;
          nxt    = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      start_q <= 1'b0;
      chip_q  <= 1'b0;
      rej_q   <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      state   <= nxt;
      start_q <= start_d;
      chip_q  <= chip_d;
      rej_q   <= rej_d;
      susp_q  <= susp_d;
    end
  end
endmodule

// File: rtl/sect_erase_window.sv
module sect_erase_window
  import sew_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int WINDOW_US   = 50,
  parameter int TIMEOUT_CYC = CLK_MHZ * WINDOW_US,
  parameter int NUM_SECT    = 16,
  parameter int SECT_W      = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [SECT_W-1:0]   cmd_sector,
  input  logic                erase_done,
  output logic                erase_begun,
  output logic                window_open,
  output logic [NUM_SECT-1:0] sector_map,
  output logic                erase_start,
  output logic                erase_chip,
  output logic                cmd_reject,
  output logic                suspend_out
);
  logic       t_load, t_run, expired;
  logic       m_clr, m_fill, m_set;
  sew_state_e state;

  sew_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .erase_done (erase_done),
    .expired    (expired),
    .t_load     (t_load),
    .t_run      (t_run),
    .m_clr      (m_clr),
    .m_fill     (m_fill),
    .m_set      (m_set),
    .state      (state),
    .start_q    (erase_start),
    .chip_q     (erase_chip),
    .rej_q      (cmd_reject),
    .susp_q     (suspend_out)
  );

  sew_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .run     (t_run),
    .expired (expired)
  );

  sew_map #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (m_clr),
    .fill    (m_fill),
    .set_en  (m_set),
    .set_idx (cmd_sector),
    .map     (sector_map)
  );

  assign erase_begun = (state == ST_LOCKED);
  assign window_open = (state == ST_WINDOW);
endmodule

// File: rtl/sew_chk.sv
module sew_chk #(
  parameter int NUM_SECT = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [1:0]          cmd_op,
  input logic                erase_done,
  input logic                erase_begun,
  input logic                window_open,
  input logic [NUM_SECT-1:0] sector_map,
  input logic                erase_start,
  input logic                erase_chip,
  input logic                cmd_reject,
  input logic                suspend_out
);
  a_r3_window_not_begun: assert property (@(posedge clk) disable iff (!rst_n)
    window_open |-> !erase_begun);

  a_r4_restart_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && cmd_valid && cmd_op == 2'd1) |=> window_open);

  a_r5_start_with_begun: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_begun && sector_map != '0));

  a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  a_r6_chip_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    erase_chip |-> (erase_begun && (&sector_map)));

  a_r7_locked_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_begun && cmd_valid && cmd_op != 2'd3) |=> cmd_reject);

  a_r7_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_begun && !erase_done) |=> (sector_map == $past(sector_map)));

  a_r8_suspend_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_begun && cmd_valid && cmd_op == 2'd3) |=> (suspend_out && !cmd_reject));

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_begun && erase_done) |=> (!erase_begun && !erase_chip && sector_map == '0));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_begun && !window_open && cmd_valid && cmd_op == 2'd0) |=> (!cmd_reject && !suspend_out));
endmodule

bind sect_erase_window sew_chk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .erase_done  (erase_done),
  .erase_begun (erase_begun),
  .window_open (window_open),
  .sector_map  (sector_map),
  .erase_start (erase_start),
  .erase_chip  (erase_chip),
  .cmd_reject  (cmd_reject),
  .suspend_out (suspend_out)
);

// File: tb/sim_sect_erase_window.sv
module sim_sect_erase_window;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int TO = 20;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, cmd_valid, erase_done;
  logic [1:0]    cmd_op;
  logic [SW-1:0] cmd_sector;
  logic          erase_begun, window_open, erase_start, erase_chip, cmd_reject, suspend_out;
  logic [NS-1:0] sector_map;

  sect_erase_window #(.TIMEOUT_CYC(TO), .NUM_SECT(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .erase_done(erase_done), .erase_begun(erase_begun),
    .window_open(window_open), .sector_map(sector_map), .erase_start(erase_start),
    .erase_chip(erase_chip), .cmd_reject(cmd_reject), .suspend_out(suspend_out));

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  // reference state: 0 idle, 1 window, 2 locked
  int            m_st, m_cnt;
  logic [NS-1:0] m_map;
  logic          m_chip, m_start, m_rej, m_susp;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [NS-1:0] bit_of(logic [SW-1:0] s);
    return NS'(1) << s;
  endfunction

  task automatic model_step(logic v, logic [1:0] op, logic [SW-1:0] s, logic d);
    m_start = 0; m_rej = 0; m_susp = 0;
    case (m_st)
      0: if (v && op == 2'd1) begin m_map |= bit_of(s); m_cnt = TO - 1; m_st = 1; end
         else if (v && op == 2'd2) begin m_map = '1; m_chip = 1; m_start = 1; m_st = 2; end
      1: if (v && op == 2'd1) begin m_map |= bit_of(s); m_cnt = TO - 1; end
         else begin
           m_rej = v;
           if (m_cnt == 0) begin m_st = 2; m_start = 1; end
           else m_cnt--;
         end
      default: begin
        if (v) begin m_susp = (op == 2'd3); m_rej = (op != 2'd3); end
        if (d) begin m_st = 0; m_map = '0; m_chip = 0; end
      end
    endcase
  endtask

  task automatic compare_all();
    chk("R3", "erase_begun", 32'(erase_begun), 32'(m_st == 2));
    chk("R2", "window_open", 32'(window_open), 32'(m_st == 1));
    chk("R4", "sector_map",  32'(sector_map),  32'(m_map));
    chk("R5", "erase_start", 32'(erase_start), 32'(m_start));
    chk("R6", "erase_chip",  32'(erase_chip),  32'(m_chip));
    chk("R7", "cmd_reject",  32'(cmd_reject),  32'(m_rej));
    chk("R8", "suspend_out", 32'(suspend_out), 32'(m_susp));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic v, logic [1:0] op, logic [SW-1:0] s, logic d);
    cmd_valid = v; cmd_op = op; cmd_sector = s; erase_done = d;
    @(posedge clk);
    model_step(v, op, s, d);
    @(negedge clk);
    cmd_valid = 0; erase_done = 0;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_sector = 0; erase_done = 0;
    m_st = 0; m_cnt = 0; m_map = '0; m_chip = 0; m_start = 0; m_rej = 0; m_susp = 0;
    repeat (3) @(negedge clk);
    chk("R1", "begun",  32'(erase_begun), 0);
    chk("R1", "window", 32'(window_open), 0);
    chk("R1", "map",    32'(sector_map),  0);
    chk("R1", "pulses", 32'({erase_start, erase_chip, cmd_reject, suspend_out}), 0);
    rst_n = 1;

    // R2/R3/R5: one sector, full window
    step(1, 2'd1, 3'd5, 0);
    chk("R2", "window after cmd", 32'(window_open), 1);
    chk("R2", "map bit5", 32'(sector_map), 32'h20);
    for (int k = 1; k < TO; k++) begin
      step(0, 2'd0, '0, 0);
      chk("R3", "begun early", 32'(erase_begun), 0);
    end
    step(0, 2'd0, '0, 0);
    chk("R3", "begun at expiry", 32'(erase_begun), 1);
    chk("R5", "start pulse", 32'(erase_start), 1);
    step(0, 2'd0, '0, 0);
    chk("R5", "start ended", 32'(erase_start), 0);

    // R7/R8/R9 in lock
    step(1, 2'd1, 3'd2, 0);
    chk("R7", "reject sector cmd", 32'(cmd_reject), 1);
    chk("R7", "map unchanged", 32'(sector_map), 32'h20);
    step(1, 2'd3, '0, 0);
    chk("R8", "suspend passed", 32'(suspend_out), 1);
    chk("R8", "suspend not rejected", 32'(cmd_reject), 0);
    step(0, 2'd0, '0, 1);
    chk("R9", "begun cleared", 32'(erase_begun), 0);
    chk("R9", "map cleared", 32'(sector_map), 0);

    // R11 / R8 idle no-effect
    step(1, 2'd0, 3'd4, 0);
    chk("R11", "other in idle", 32'({cmd_reject, window_open, sector_map}), 0);
    step(1, 2'd3, '0, 0);
    chk("R8", "suspend in idle", 32'({suspend_out, cmd_reject}), 0);

    // R4 restart, R10 reject in window
    step(1, 2'd1, 3'd1, 0);
    idle(9);
    step(1, 2'd1, 3'd6, 0);
    chk("R4", "map accumulates", 32'(sector_map), 32'h42);
    step(1, 2'd2, '0, 0);
    chk("R10", "chip rejected in window", 32'(cmd_reject), 1);
    chk("R10", "map kept", 32'(sector_map), 32'h42);
    for (int k = 2; k < TO; k++) begin
      step(0, 2'd0, '0, 0);
      chk("R4", "restart holds window", 32'(erase_begun), 0);
    end
    step(0, 2'd0, '0, 0);
    chk("R4", "begun after restart", 32'(erase_begun), 1);
    chk("R10", "reject did not restart", 32'(erase_start), 1);
    step(0, 2'd0, '0, 1);

    // R6 chip erase bypass
    step(1, 2'd2, '0, 0);
    chk("R6", "chip begun", 32'({erase_begun, erase_start, erase_chip}), 32'h7);
    chk("R6", "chip map", 32'(sector_map), 32'hFF);
    step(0, 2'd0, '0, 1);
    chk("R9", "chip cleared", 32'({erase_begun, erase_chip}), 0);
    step(0, 2'd0, '0, 1);
    chk("R9", "done in idle ignored", 32'({erase_begun, window_open, sector_map}), 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic v, d;
      v = ($urandom_range(0, 7) == 0);
      d = (m_st == 2) && ($urandom_range(0, 9) == 0);
      step(v, 2'($urandom_range(0, 3)), SW'($urandom_range(0, NS - 1)), d);
    end
    finish_run();
  end
endmodule